// File: doc/BRIEF.md
# Programmable Crosspoint Switch with Destination Steering

This block is an N×N switching matrix for an on-chip router. Every crosspoint between an input row and an output column holds a two-bit mode. A mode can keep the crosspoint open or closed at all times. It can also close the crosspoint only for packets whose leading destination word names that column. A crosspoint can also be locked open to fence off a faulty path. Because any number of crosspoints may be closed in a row or a column, the stored modes describe a topology laid out in space, for example one input fanned out to several outputs. That topology persists until it is rewritten.

Two write ports load the modes. The reconfiguration port has full authority. The instruction port may only load the two "closed" flavours and is refused anything else. At each input, a small destination analyzer takes the first word of a packet as a routing word and does not forward it. It holds the destination until the packet's last word. When several inputs reach the same output in one cycle, the lowest-numbered input is passed and a conflict flag marks that output.

Top module: `xbar_route`

## Requirements
- R1: The matrix size N is a parameter with default 10, and a 4×4 instance routes correctly; each data lane is W bits wide, with W no smaller than the destination index width.
- R2: Mode codes per crosspoint: 2'b00 open, 2'b01 always closed, 2'b11 locked open (faulty); a payload word passes an open or locked crosspoint to no output.
- R3: Several crosspoints in one row may be closed together, so one input's payload appears on several outputs in the same cycle.
- R4: An instruction-port write of 2'b01 or 2'b10 is stored; one of 2'b00 or 2'b11 leaves the crosspoint unchanged and raises ip_err for the single cycle after the write.
- R5: The reconfiguration port stores any code; when both ports write the same crosspoint in one cycle, the reconfiguration value is kept.
- R6: Mode 2'b10 closes a crosspoint only while that input's latched destination equals the column index.
- R7: The first valid word of a packet is a routing word whose low bits (index width) give the destination; it reaches no output, and the destination is held until the word flagged last.
- R8: Stored modes persist across packet ends until rewritten, and a write changes routing from the cycle after it is accepted, not in the cycle it is presented.
- R9: If several inputs reach one output in a cycle, the lowest-numbered input's data is driven and that output's conflict flag is 1; with one driver the flag is 0.
- R10: After reset all modes are open, no packet is in progress, and ip_err, out_valid and out_conflict are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ru_we | input | 1 | Reconfiguration-port write strobe |
| ru_row | input | $clog2(N) | Input row of the crosspoint written |
| ru_col | input | $clog2(N) | Output column of the crosspoint written |
| ru_code | input | 2 | Mode code written by the reconfiguration port |
| ip_we | input | 1 | Instruction-port write strobe |
| ip_row | input | $clog2(N) | Input row for the instruction write |
| ip_col | input | $clog2(N) | Output column for the instruction write |
| ip_code | input | 2 | Mode code requested by the instruction port |
| ip_err | output | 1 | Rejected instruction write, one cycle after it |
| in_valid | input | N | Per-input word valid |
| in_last | input | N | Per-input last word of packet |
| in_data | input | N*W | Input words, lane i at bits i*W +: W |
| out_valid | output | N | Per-output word valid |
| out_data | output | N*W | Output words, lane j at bits j*W +: W |
| out_conflict | output | N | More than one input reached this output |

## Verification
The hardest state to reach is a mode write landing in the very cycle a payload word is crossing the same crosspoint: the bench holds an input mid-packet, presents the write on that cycle and checks the old routing before the clock edge and the new one after it. Rejected instruction writes are also aimed at crosspoints that already carry a live route, so the refused write can be seen to leave traffic intact. Conflicts are produced by closing two rows onto one column statically and lining their payload words up in one cycle.

// File: rtl/xbar_route.sv
module xbar_route #(
  parameter int N = 10,
  parameter int W = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ru_we,
  input  logic [IW-1:0]  ru_row,
  input  logic [IW-1:0]  ru_col,
  input  logic [1:0]     ru_code,
  input  logic           ip_we,
  input  logic [IW-1:0]  ip_row,
  input  logic [IW-1:0]  ip_col,
  input  logic [1:0]     ip_code,
  output logic           ip_err,
  input  logic [N-1:0]   in_valid,
  input  logic [N-1:0]   in_last,
  input  logic [N*W-1:0] in_data,
  output logic [N-1:0]   out_valid,
  output logic [N*W-1:0] out_data,
  output logic [N-1:0]   out_conflict
);

  logic [2*N*N-1:0] cfg_q;
  logic [N-1:0]     busy;
  logic [IW-1:0]    dest [N];
  logic [N-1:0]     active;
  logic [N-1:0]     conn [N];
  logic             ip_ok;

  assign ip_ok  = (ip_code == 2'b01) || (ip_code == 2'b10);
  assign active = in_valid & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ip_err <= 1'b0;
    end else begin
      ip_err <= ip_we && !ip_ok;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (ru_we && int'(ru_row) == i && int'(ru_col) == j)
            cfg_q[2*(i*N+j) +: 2] <= ru_code;
          else if (ip_we && ip_ok && int'(ip_row) == i && int'(ip_col) == j)
            cfg_q[2*(i*N+j) +: 2] <= ip_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      for (int i = 0; i < N; i++) dest[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if (in_valid[i]) begin
          if (!busy[i]) begin
            dest[i] <= in_data[i*W +: IW];
            busy[i] <= !in_last[i];
          end else if (in_last[i]) begin
            busy[i] <= 1'b0;
          end
        end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        case (cfg_q[2*(i*N+j) +: 2])
          2'b01:   conn[i][j] = 1'b1;
          2'b10:   conn[i][j] = busy[i] && (int'(dest[i]) == j);
          default: conn[i][j] = 1'b0;
        endcase
  end

  always_comb begin
    out_valid    = '0;
    out_data     = '0;
    out_conflict = '0;
    for (int j = 0; j < N; j++) begin
      int cnt;
      cnt = 0;
      for (int i = N-1; i >= 0; i--)
        if (active[i] && conn[i][j]) begin
          cnt++;
          out_valid[j]        = 1'b1;
          out_data[j*W +: W]  = in_data[i*W +: W];
        end
      out_conflict[j] = (cnt > 1);
    end
  end

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ru_we && !ip_we |=> $stable(cfg_q));

  assert_ip_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ip_we && !ip_ok && !ru_we |=> $stable(cfg_q));

  assert_err_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ip_err |-> $past(ip_we));

  assert_ru_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ru_we && int'(ru_row) < N && int'(ru_col) < N |=>
    cfg_q[2*(int'($past(ru_row))*N + int'($past(ru_col))) +: 2] == $past(ru_code));

  assert_header_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active == '0 |-> out_valid == '0);

  generate
    for (genvar j = 0; j < N; j++) begin : g_chk
      assert_conflict_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_conflict[j] |-> out_valid[j]);
    end
  endgenerate

endmodule

// File: tb/xbar_route_tb.sv
`timescale 1ns/1ps
module xbar_route_tb;
  localparam int N = 10, W = 16, IW = 4;
  localparam int N4 = 4, W4 = 8, IW4 = 2;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic ru_we = 0, ip_we = 0;
  logic [IW-1:0] ru_row = 0, ru_col = 0, ip_row = 0, ip_col = 0;
  logic [1:0] ru_code = 0, ip_code = 0;
  logic ip_err;
  logic [N-1:0] in_valid = 0, in_last = 0, out_valid, out_conflict;
  logic [N*W-1:0] in_data = 0, out_data;

  logic ru4_we = 0;
  logic [IW4-1:0] ru4_row = 0, ru4_col = 0;
  logic [1:0] ru4_code = 0;
  logic ip4_err;
  logic [N4-1:0] v4 = 0, l4 = 0, ov4, oc4;
  logic [N4*W4-1:0] d4 = 0, od4;

  int checks = 0, errors = 0;

  xbar_route #(.N(N), .W(W)) u_dut (
    .clk, .rst_n, .ru_we, .ru_row, .ru_col, .ru_code,
    .ip_we, .ip_row, .ip_col, .ip_code, .ip_err,
    .in_valid, .in_last, .in_data, .out_valid, .out_data, .out_conflict);

  xbar_route #(.N(N4), .W(W4)) u_dut4 (
    .clk, .rst_n, .ru_we(ru4_we), .ru_row(ru4_row), .ru_col(ru4_col), .ru_code(ru4_code),
    .ip_we(1'b0), .ip_row('0), .ip_col('0), .ip_code(2'b00), .ip_err(ip4_err),
    .in_valid(v4), .in_last(l4), .in_data(d4), .out_valid(ov4), .out_data(od4),
    .out_conflict(oc4));

  // fields: in[14:11] code[10:9] dest[8:5] out[4:1] expect[0]
  localparam logic [14:0] VEC [6] = '{
    {4'd0, 2'b01, 4'd9, 4'd3, 1'b1},
    {4'd2, 2'b10, 4'd5, 4'd5, 1'b1},
    {4'd4, 2'b10, 4'd6, 4'd5, 1'b0},
    {4'd7, 2'b11, 4'd7, 4'd7, 1'b0},
    {4'd9, 2'b00, 4'd0, 4'd0, 1'b0},
    {4'd5, 2'b01, 4'd0, 4'd9, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ru_wr(input int r, input int c, input logic [1:0] code);
    @(negedge clk);
    ru_we = 1; ru_row = IW'(r); ru_col = IW'(c); ru_code = code;
    @(negedge clk);
    ru_we = 0;
  endtask

  task automatic ip_wr(input int r, input int c, input logic [1:0] code);
    @(negedge clk);
    ip_we = 1; ip_row = IW'(r); ip_col = IW'(c); ip_code = code;
    @(negedge clk);
    ip_we = 0;
  endtask

  task automatic word(input int i, input logic [W-1:0] d, input logic last);
    in_valid[i] = 1; in_last[i] = last; in_data[i*W +: W] = d;
  endtask

  task automatic idle(input int i);
    in_valid[i] = 0; in_last[i] = 0; in_data[i*W +: W] = '0;
  endtask

  // header then one payload word; checks out_valid at column c
  task automatic pkt(input int i, input int dst, input logic [W-1:0] d, input int c,
                     input logic exp, input string tag);
    @(negedge clk); word(i, W'(dst), 0);
    #1 check({tag, " header not forwarded R7"}, 32'(out_valid), 0);
    @(negedge clk); word(i, d, 1);
    #1 check(tag, 32'(out_valid[c]), 32'(exp));
    if (exp) check({tag, " data"}, 32'(out_data[c*W +: W]), 32'(d));
    @(negedge clk); idle(i);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    #1 check("R10 ip_err", 32'(ip_err), 0);
    check("R10 out_valid", 32'(out_valid), 0);
    check("R10 out_conflict", 32'(out_conflict), 0);
    pkt(0, 3, 16'h1111, 3, 0, "R10 modes open after reset");

    // table of route vectors: R2 R6
    for (int k = 0; k < 6; k++) begin
      logic [14:0] v;
      v = VEC[k];
      ru_wr(int'(v[14:11]), int'(v[4:1]), v[10:9]);
      pkt(int'(v[14:11]), int'(v[8:5]), W'(16'hA000 + k), int'(v[4:1]), v[0],
          $sformatf("R2/R6 vector %0d", k));
      ru_wr(int'(v[14:11]), int'(v[4:1]), 2'b00);
    end

    // R4 instruction port
    ip_wr(1, 2, 2'b01);
    #1 check("R4 accepted write no err", 32'(ip_err), 0);
    pkt(1, 0, 16'h0102, 2, 1, "R4 ip code 01 stored");
    ip_wr(1, 2, 2'b00);
    #1 check("R4 reject 00 err", 32'(ip_err), 1);
    @(negedge clk); #1 check("R4 err one cycle", 32'(ip_err), 0);
    pkt(1, 0, 16'h0203, 2, 1, "R4 rejected 00 left cell");
    ip_wr(1, 2, 2'b11);
    #1 check("R4 reject 11 err", 32'(ip_err), 1);
    pkt(1, 0, 16'h0304, 2, 1, "R4 rejected 11 left cell");
    ip_wr(1, 2, 2'b10);
    pkt(1, 7, 16'h0405, 2, 0, "R4 ip code 10 stored, dest mismatch");
    pkt(1, 2, 16'h0506, 2, 1, "R4 R6 ip code 10 dest match");

    // R5 both ports same cell
    @(negedge clk);
    ru_we = 1; ru_row = 1; ru_col = 2; ru_code = 2'b00;
    ip_we = 1; ip_row = 1; ip_col = 2; ip_code = 2'b01;
    @(negedge clk); ru_we = 0; ip_we = 0;
    pkt(1, 2, 16'h0607, 2, 0, "R5 reconfig port wins");
    ru_wr(1, 2, 2'b11);
    pkt(1, 2, 16'h0708, 2, 0, "R5 R2 locked code 11");

    // R3 fanout
    ru_wr(3, 0, 2'b01); ru_wr(3, 1, 2'b01); ru_wr(3, 8, 2'b01);
    @(negedge clk); word(3, 16'h0, 0);
    @(negedge clk); word(3, 16'hBEEF, 1);
    #1 check("R3 fanout lanes", 32'(out_valid), 32'b01_0000_0011);
    check("R3 fanout data col 8", 32'(out_data[8*W +: W]), 32'hBEEF);
    @(negedge clk); idle(3);

    // R8 persistence and next-cycle effect
    pkt(3, 4, 16'hC0DE, 1, 1, "R8 route survives packet end");
    @(negedge clk); word(0, 16'h0, 0);
    @(negedge clk); word(0, 16'h0A0A, 0);
    ru_we = 1; ru_row = 0; ru_col = 5; ru_code = 2'b01;
    #1 check("R8 write not yet effective", 32'(out_valid[5]), 0);
    @(negedge clk); ru_we = 0; word(0, 16'h0B0B, 1);
    #1 check("R8 write effective next cycle", 32'(out_valid[5]), 1);
    @(negedge clk); idle(0);
    ru_wr(0, 5, 2'b00);

    // R7 destination held across words, R6 retarget on next packet
    ru_wr(6, 4, 2'b10); ru_wr(6, 7, 2'b10);
    @(negedge clk); word(6, 16'h0004, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); word(6, W'(16'h6000 + k), k == 2);
      #1 check("R7 dest held", 32'(out_valid), 32'b00_0001_0000);
    end
    pkt(6, 7, 16'h6700, 7, 1, "R6 new packet new dest");

    // R9 conflict
    ru_wr(1, 9, 2'b01); ru_wr(6, 9, 2'b01);
    @(negedge clk); word(1, 16'h0, 0); word(6, 16'h0, 0);
    @(negedge clk); word(1, 16'h1AAA, 1); word(6, 16'h6BBB, 1);
    #1 check("R9 conflict flag", 32'(out_conflict[9]), 1);
    check("R9 lowest wins", 32'(out_data[9*W +: W]), 32'h1AAA);
    @(negedge clk); idle(1); idle(6);
    pkt(6, 0, 16'h6CCC, 9, 1, "R9 single driver");
    check("R9 no conflict single", 32'(out_conflict[9]), 0);

    // R1 4x4 instance
    @(negedge clk); ru4_we = 1; ru4_row = 3; ru4_col = 0; ru4_code = 2'b01;
    @(negedge clk); ru4_row = 1; ru4_col = 2; ru4_code = 2'b10;
    @(negedge clk); ru4_we = 0;
    v4 = 4'b1010; d4 = {8'h00, 8'h00, 8'h02, 8'h00};
    @(negedge clk); l4 = 4'b1010; d4 = {8'h33, 8'h00, 8'h11, 8'h00};
    #1 check("R1 4x4 valid", 32'(ov4), 32'b0101);
    check("R1 4x4 data", 32'(od4), {8'h00, 8'h11, 8'h00, 8'h33});
    check("R1 4x4 no conflict", 32'(oc4), 0);
    @(negedge clk); v4 = 0; l4 = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule